// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Unit

This block sums two signed pre-adder operands, multiplies that sum by a signed multiplier operand, and adds the product into a running accumulator. A single-bit carry-in is added in the same step. A load strobe replaces the accumulator with an external value instead of accumulating.

A single active-high clock enable gates every register in the block. The `LATENCY` parameter (0 to 4) sets how many register stages lie between the inputs and `prod_o`. These stages are split between an operand stage, a stage after the multiplier, and a stage at the output:

| LATENCY | operand stages | register after multiplier | output register |
|---|---|---|---|
| 0 | 0 | no | no |
| 1 | 0 | yes | no |
| 2 | 1 | yes | no |
| 3 | 1 | yes | yes |
| 4 | 2 | yes | yes |

The load strobe, the load value and the carry-in travel through the same stages as the operands they arrive with. The accumulator itself is always a register. When the block has no output register, `prod_o` is the value the accumulator will take at the next enabled edge.

Top module: `preadd_mac`

## Requirements
- R1: At each enabled edge without load, the accumulator becomes acc + (pre_a + pre_b) * mul + carry. All operands are signed two's complement, sign-extended to PROD_W, and the sum wraps modulo 2^PROD_W.
- R2: With load set on a vector, the accumulator takes load_data for that vector. The operands and carry-in of that vector have no effect.
- R3: carry_i = 1 adds exactly one to the accumulated value of its vector. This includes wrapping from all ones to zero.
- R4: While ce_i is low, no register changes. With an output register (LATENCY 3 or 4), prod_o holds its value.
- R5: With LATENCY 0, prod_o follows the inputs combinationally in the same cycle: it equals the next accumulator value.
- R6: A vector accepted at an enabled edge reaches prod_o after exactly LATENCY enabled edges, counting only edges with ce_i high.
- R7: Load, load data and carry-in are delayed through the same stages as the operands they arrive with.
- R8: When rst_ni is low, all registers clear asynchronously. With zero inputs, prod_o then reads 0 at every latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Active-high clock enable for all registers |
| load_i | input | 1 | Replace accumulator with load_data_i |
| load_data_i | input | PROD_W | Value loaded into the accumulator |
| carry_i | input | 1 | Carry-in added to the accumulation |
| pre_a_i | input | PRE_W | First signed pre-adder operand |
| pre_b_i | input | PRE_W | Second signed pre-adder operand |
| mul_i | input | MUL_W | Signed multiplier operand |
| prod_o | output | PROD_W | Accumulator result |

## Verification
On every cycle, the assertions check three things. The accumulator takes the load value when load is set. It takes the sum of itself, the extended product and the carry otherwise. It and every pipeline stage hold while the clock enable is low. Only the bench's scenarios can show how the stages line up against the LATENCY setting. The same holds for the combinational path at latency 0, the alignment of load and carry with their operands, and wrap-around at the extremes. For these, the bench runs all five latencies side by side against a delayed reference model.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;
  function automatic int op_stages(input int lat);
    case (lat)
      0, 1:    return 0;
      2, 3:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int has_mreg(input int lat);
    return (lat >= 1) ? 1 : 0;
  endfunction

  function automatic int has_oreg(input int lat);
    return (lat >= 3) ? 1 : 0;
  endfunction
endpackage

// File: rtl/pmac_delay.sv
module pmac_delay #(
  parameter int W = 8,
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (N == 0) begin : g_pass
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] r_q [N];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < N; k++) r_q[k] <= '0;
      end else if (ce_i) begin
        r_q[0] <= d_i;
        for (int k = 1; k < N; k++) r_q[k] <= r_q[k-1];
      end
    end

    assign q_o = r_q[N-1];

    assert_stage_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ce_i |=> $stable(q_o));
  end
endmodule

// File: rtl/pmac_mult.sv
module pmac_mult #(
  parameter int PRE_W = 24,
  parameter int MUL_W = 18,
  localparam int SUM_W = PRE_W + 1,
  localparam int XP_W  = SUM_W + MUL_W
) (
  input  logic [PRE_W-1:0] a_i,
  input  logic [PRE_W-1:0] b_i,
  input  logic [MUL_W-1:0] m_i,
  output logic [XP_W-1:0]  p_o
);
  logic signed [SUM_W-1:0] sum;
  logic signed [XP_W-1:0]  sum_x, mul_x;

  assign sum   = $signed({a_i[PRE_W-1], a_i}) + $signed({b_i[PRE_W-1], b_i});
  assign sum_x = {{MUL_W{sum[SUM_W-1]}}, sum};
  assign mul_x = {{SUM_W{m_i[MUL_W-1]}}, m_i};
  // full product fits in XP_W, so truncation is exact
  assign p_o   = sum_x * mul_x;
endmodule

// File: rtl/pmac_acc.sv
module pmac_acc #(
  parameter int XP_W   = 43,
  parameter int PROD_W = 48,
  parameter int OREG   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [XP_W-1:0]   p_i,
  input  logic              load_i,
  input  logic [PROD_W-1:0] load_data_i,
  input  logic              carry_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [PROD_W-1:0] p_ext, acc_q, acc_d;

  if (XP_W >= PROD_W) begin : g_trunc
    assign p_ext = p_i[PROD_W-1:0];
  end else begin : g_sext
    assign p_ext = {{(PROD_W-XP_W){p_i[XP_W-1]}}, p_i};
  end

  assign acc_d = load_i ? load_data_i : acc_q + p_ext + PROD_W'(carry_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (ce_i) acc_q <= acc_d;
  end

  if (OREG != 0) begin : g_oreg
    assign prod_o = acc_q;
  end else begin : g_comb
    assign prod_o = acc_d;
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && load_i) |=> acc_q == $past(load_data_i));

  assert_accum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !load_i) |=> acc_q == $past(acc_q + p_ext + PROD_W'(carry_i)));

  assert_acc_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(acc_q));
endmodule

// File: rtl/preadd_mac.sv
module preadd_mac #(
  parameter int PRE_W   = 24,
  parameter int MUL_W   = 18,
  parameter int PROD_W  = 48,
  parameter int LATENCY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              load_i,
  input  logic [PROD_W-1:0] load_data_i,
  input  logic              carry_i,
  input  logic [PRE_W-1:0]  pre_a_i,
  input  logic [PRE_W-1:0]  pre_b_i,
  input  logic [MUL_W-1:0]  mul_i,
  output logic [PROD_W-1:0] prod_o
);
  import preadd_mac_pkg::*;

  localparam int OPS   = op_stages(LATENCY);
  localparam int MREG  = has_mreg(LATENCY);
  localparam int OREG  = has_oreg(LATENCY);
  localparam int XP_W  = PRE_W + 1 + MUL_W;
  localparam int CTL_W = PROD_W + 2;
  localparam int OPD_W = 2 * PRE_W + MUL_W + CTL_W;

  // control fields ride with their operands
  logic [OPD_W-1:0]       opd_q;
  logic [PRE_W-1:0]       a_s, b_s;
  logic [MUL_W-1:0]       m_s;
  logic [CTL_W-1:0]       ctl_s, ctl_m;
  logic [XP_W-1:0]        xp, xp_m;

  pmac_delay #(.W(OPD_W), .N(OPS)) u_opd (
    .clk_i, .rst_ni, .ce_i,
    .d_i({pre_a_i, pre_b_i, mul_i, load_i, load_data_i, carry_i}),
    .q_o(opd_q)
  );

  assign {a_s, b_s, m_s, ctl_s} = opd_q;

  pmac_mult #(.PRE_W(PRE_W), .MUL_W(MUL_W)) u_mul (
    .a_i(a_s), .b_i(b_s), .m_i(m_s), .p_o(xp)
  );

  pmac_delay #(.W(XP_W + CTL_W), .N(MREG)) u_mreg (
    .clk_i, .rst_ni, .ce_i,
    .d_i({xp, ctl_s}),
    .q_o({xp_m, ctl_m})
  );

  pmac_acc #(.XP_W(XP_W), .PROD_W(PROD_W), .OREG(OREG)) u_acc (
    .clk_i, .rst_ni, .ce_i,
    .p_i(xp_m),
    .load_i(ctl_m[CTL_W-1]),
    .load_data_i(ctl_m[PROD_W:1]),
    .carry_i(ctl_m[0]),
    .prod_o
  );
endmodule

// File: tb/tb_preadd_mac.sv
`timescale 1ns/1ps
module tb_preadd_mac;
  localparam int NL = 5;

  typedef struct {
    longint a, b, m, ldd;
    bit     ld, cin;
  } vec_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce = 1'b0, ld = 1'b0, cin = 1'b0;
  logic [47:0] ldd = '0;
  logic [23:0] pa = '0, pb = '0;
  logic [17:0] mu = '0;
  logic [47:0] prod [NL];

  int     n_chk = 0, n_bad = 0;
  longint acc_m [NL];
  vec_t   hist [3];
  int     dly [NL] = '{0, 1, 2, 2, 3};
  bit     oreg [NL] = '{0, 0, 0, 1, 1};

  always #5 clk = ~clk;

  for (genvar g = 0; g < NL; g++) begin : g_lat
    preadd_mac #(.LATENCY(g)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .load_i(ld),
      .load_data_i(ldd), .carry_i(cin), .pre_a_i(pa), .pre_b_i(pb),
      .mul_i(mu), .prod_o(prod[g])
    );
  end

  task automatic check(input string tag, input int lat, input logic [47:0] got,
                       input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s lat%0d: got %h expected %h", tag, lat, got, exp);
    end
  endtask

  function automatic longint next_acc(input int i, input vec_t v);
    if (v.ld) return v.ldd;
    return acc_m[i] + (v.a + v.b) * v.m + longint'(v.cin);
  endfunction

  task automatic step(input longint a, input longint b, input longint m,
                      input bit l, input longint d, input bit c, input bit e,
                      input string tag);
    vec_t cur, av;
    longint nx [NL];
    @(negedge clk);
    pa = a[23:0]; pb = b[23:0]; mu = m[17:0];
    ld = l; ldd = d[47:0]; cin = c; ce = e;
    cur.a = a; cur.b = b; cur.m = m; cur.ld = l; cur.ldd = d; cur.cin = c;
    #1;
    for (int i = 0; i < NL; i++) begin
      av = (dly[i] == 0) ? cur : hist[dly[i]-1];
      nx[i] = next_acc(i, av);
      check(tag, i, prod[i], oreg[i] ? acc_m[i][47:0] : nx[i][47:0]);
    end
    @(posedge clk);
    if (e) begin
      for (int i = 0; i < NL; i++) acc_m[i] = nx[i];
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = cur;
    end
  endtask

  task automatic flush(input string tag);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  // R8
  task automatic t_reset();
    vec_t z;
    z.a = 0; z.b = 0; z.m = 0; z.ldd = 0; z.ld = 0; z.cin = 0;
    rst_ni = 1'b0; ce = 1'b1;
    for (int i = 0; i < NL; i++) acc_m[i] = 0;
    for (int k = 0; k < 3; k++) hist[k] = z;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NL; i++) check("R8", i, prod[i], 48'h0);
    rst_ni = 1'b1;
  endtask

  // R1, R5, R6
  task automatic t_accum();
    step(3, 4, 5, 0, 0, 0, 1, "R1");
    step(-10, 2, 7, 0, 0, 0, 1, "R1");
    step(100, -300, -9, 0, 0, 0, 1, "R5");
    for (int k = 0; k < 12; k++)
      step(longint'($signed(24'($urandom))), longint'($signed(24'($urandom))),
           longint'($signed(18'($urandom))), 0, 0, 0, 1, "R6");
    flush("R6");
  endtask

  // R3
  task automatic t_carry();
    step(0, 0, 0, 1, 48'hFFFF_FFFF_FFFE, 0, 1, "R3");
    step(0, 0, 0, 0, 0, 1, 1, "R3");
    step(0, 0, 0, 0, 0, 1, 1, "R3");
    step(1, 1, 1, 0, 0, 1, 1, "R3");
    flush("R3");
  endtask

  // R2, R7
  task automatic t_load();
    step(5, 5, 5, 1, 48'h0000_1234_5678, 1, 1, "R2");
    step(2, 3, 4, 0, 48'hFFFF, 0, 1, "R7");
    step(-1, -1, 9, 1, 48'h8000_0000_0000, 0, 1, "R7");
    step(7, 0, 3, 0, 0, 1, 1, "R2");
    flush("R2");
  endtask

  // R4
  task automatic t_hold();
    step(11, 22, 33, 0, 0, 1, 1, "R4");
    step(1000, 1000, 1000, 1, 48'hABCD, 1, 0, "R4");
    step(-5, 6, -7, 0, 0, 0, 0, "R4");
    step(9, 9, 9, 0, 0, 0, 1, "R4");
    step(4, 4, 4, 0, 0, 0, 0, "R4");
    step(1, 2, 3, 0, 0, 0, 1, "R4");
    flush("R4");
  endtask

  // R1 extremes
  task automatic t_extreme();
    step(0, 0, 0, 1, 0, 0, 1, "R1");
    step(-(1 << 23), -(1 << 23), -(1 << 17), 0, 0, 0, 1, "R1");
    step((1 << 23) - 1, (1 << 23) - 1, (1 << 17) - 1, 0, 0, 1, 1, "R1");
    step(-(1 << 23), 0, (1 << 17) - 1, 0, 0, 0, 1, "R1");
    flush("R1");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_accum();
    t_carry();
    t_load();
    t_hold();
    t_extreme();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule